// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. A prescaler divides the system clock by four to make one conversion count. The block then runs a fixed-length measurement cycle of four phases: it zeroes the integrator and comparator offsets, integrates the unknown input for a fixed time, and de-integrates against a reference of opposite sign until a single-bit comparator reports that the integrator has returned to zero. A final phase drives the integrator back to zero before the next cycle. The analog switches follow the one-hot phase outputs and the reference-polarity select.

The de-integrate time is counted in decade counters. At the end of de-integrate the count is latched as a 3½-digit reading, together with a polarity flag and an overrange flag, and a one-clock strobe marks the new reading. Every cycle lasts 4000 counts whatever the input. The auto-zero phase absorbs the unused part of the de-integrate window. After an overranged conversion the integrator-zeroing phase is lengthened, so a saturated integrator recovers within that same cycle.

Top module: `dslope_seq`

## Requirements
- R1: One count lasts four clocks. The prescaler is cleared by reset, and phase changes occur only on the 4th, 8th, 12th, ... clock edge after reset is released.
- R2: A synchronous active-high reset gives `phase_o` = 4'b0001 and clears `ref_pos_o`, `valid_o`, `neg_o`, `ovr_o`, `thou_o` and `bcd_o`. The first auto-zero after release lasts 260 counts (1040 clocks).
- R3: `phase_o` is always one-hot, with bit 0 auto-zero, bit 1 signal integrate, bit 2 de-integrate and bit 3 integrator zeroing. The phases follow each other in that order and wrap from bit 3 back to bit 0.
- R4: Signal integrate lasts exactly 1000 counts (4000 clocks).
- R5: On the last clock edge of signal integrate, `cmp_i` (1 = integrator above zero) is captured into `ref_pos_o`. `ref_pos_o` holds that value until the next signal-integrate end.
- R6: De-integrate ends on the first count edge at which `cmp_i` differs from `ref_pos_o`. The reading is the number of counts completed before that edge (0 to 1999), and the phase lasts the reading plus one count.
- R7: If 2000 counts pass in de-integrate without a crossing, the phase ends, `ovr_o` is set and the reading digits are cleared to zero.
- R8: Integrator zeroing lasts 140 counts, or 740 counts when the de-integrate just before it overranged.
- R9: The time from one signal-integrate start to the next is always 4000 counts (16000 clocks). Auto-zero lasts 4000 minus 1000 minus the de-integrate length minus the zeroing length.
- R10: On the clock after de-integrate ends, `valid_o` is high for exactly one clock. In that same clock, `bcd_o`, `thou_o`, `ovr_o` and `neg_o` (the inverse of `ref_pos_o`) take their new values, and they are otherwise held.
- R11: The reading is coded as `bcd_o[3:0]` units, `bcd_o[7:4]` tens and `bcd_o[11:8]` hundreds, each 0 to 9, with `thou_o` as the thousands digit (0 or 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmp_i | input | 1 | Comparator: 1 when the integrator output is above zero |
| phase_o | output | 4 | One-hot phase select: auto-zero, integrate, de-integrate, zeroing |
| ref_pos_o | output | 1 | Input polarity captured at integrate end; selects the discharging reference |
| valid_o | output | 1 | One-clock strobe for a new reading |
| neg_o | output | 1 | Latched reading is negative |
| ovr_o | output | 1 | Latched reading overranged |
| thou_o | output | 1 | Thousands (half) digit of the reading |
| bcd_o | output | 12 | Hundreds, tens and units BCD digits |

## Verification
The bench drives the comparator from an integer integrator ramp. The ramp is charged by a sequence of inputs that covers positive, negative and zero values, a crossing on the very last count of the de-integrate window, and overranges of both signs. The last-count crossing exposes an off-by-one that would wrongly report overrange or a reading of 2000. An overrange that does not extend the following zeroing phase, or does not shorten the next auto-zero to match, breaks the fixed 16000-clock period. Capturing the polarity a count early or late, or letting the reading registers change outside the strobe, shows up as a mismatch on the cycle-by-cycle comparison.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DEI = 2'd2,
    PH_ZI  = 2'd3
  } phase_e;

  // Auto-zero receives whatever is left of the fixed cycle.
  function automatic int unsigned fill_len(int unsigned cycle_cnt,
                                           int unsigned int_cnt,
                                           int unsigned dei_cnt,
                                           int unsigned zi_cnt);
    return cycle_cnt - int_cnt - dei_cnt - zi_cnt;
  endfunction

  function automatic logic [3:0] phase_onehot(phase_e p);
    return 4'b0001 << p;
  endfunction

endpackage

// File: rtl/dslope_prescale.sv
module dslope_prescale #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);

  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  assign tick_o = (cnt == W'(DIV - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/dslope_bcd.sv
module dslope_bcd #(
  parameter int DIGITS = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  clr_i,
  input  logic                  inc_i,
  output logic                  half_o,
  output logic [4*DIGITS-1:0]   bcd_o
);

  logic [DIGITS:0] carry;

  assign carry[0] = inc_i;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] d;
    logic       at9;
    assign at9          = (d == 4'd9);
    assign carry[i+1]   = carry[i] & at9;
    assign bcd_o[4*i+:4] = d;
    always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) d <= 4'd0;
      else if (carry[i])  d <= at9 ? 4'd0 : d + 4'd1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i)      half_o <= 1'b0;
    else if (carry[DIGITS])  half_o <= ~half_o;
  end

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int INT_CNT = 1000,
  parameter int DEI_MAX = 2000,
  parameter int ZI_NORM = 140,
  parameter int ZI_LONG = 740,
  parameter int CYCLE   = 4000,
  parameter int DIGITS  = 3
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                cmp_i,
  output logic [3:0]          phase_o,
  output logic                ref_pos_o,
  output logic                valid_o,
  output logic                neg_o,
  output logic                ovr_o,
  output logic                thou_o,
  output logic [4*DIGITS-1:0] bcd_o
);

  localparam int          CW      = $clog2(CYCLE + 1);
  localparam int unsigned AZ_BOOT = CYCLE - INT_CNT - DEI_MAX - ZI_LONG;

  phase_e                ph;
  logic [CW-1:0]         pc;
  logic [CW-1:0]         az_len;
  logic [CW-1:0]         cur_len;
  logic                  long_zi;
  logic                  pos_q;

  // Named internal events
  logic                  tick;
  logic                  in_dei;
  logic                  dei_cross;
  logic                  dei_full;
  logic                  dei_done;
  logic                  timed_end;
  logic                  adv;
  logic                  int_end;
  logic [CW-1:0]         dei_used;
  logic [CW-1:0]         zi_next;
  logic [CW-1:0]         az_next;
  logic                  cnt_half;
  logic [4*DIGITS-1:0]   cnt_bcd;

  dslope_prescale #(.DIV(DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_o (tick)
  );

  assign in_dei    = (ph == PH_DEI);
  assign dei_cross = tick & in_dei & (cmp_i != pos_q);
  assign dei_full  = tick & in_dei & ~dei_cross & (pc == CW'(DEI_MAX - 1));
  assign dei_done  = dei_cross | dei_full;

  always_comb begin
    case (ph)
      PH_AZ:   cur_len = az_len;
      PH_INT:  cur_len = CW'(INT_CNT);
      PH_ZI:   cur_len = long_zi ? CW'(ZI_LONG) : CW'(ZI_NORM);
      default: cur_len = CW'(DEI_MAX);
    endcase
  end

  assign timed_end = tick & ~in_dei & (pc == cur_len - CW'(1));
  assign adv       = timed_end | dei_done;
  assign int_end   = adv & (ph == PH_INT);

  assign dei_used = dei_full ? CW'(DEI_MAX) : pc + CW'(1);
  assign zi_next  = dei_full ? CW'(ZI_LONG) : CW'(ZI_NORM);
  assign az_next  = CW'(fill_len(CYCLE, INT_CNT, 32'(dei_used), 32'(zi_next)));

  dslope_bcd #(.DIGITS(DIGITS)) u_bcd (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (int_end),
    .inc_i  (tick & in_dei & ~dei_done),
    .half_o (cnt_half),
    .bcd_o  (cnt_bcd)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph      <= PH_AZ;
      pc      <= '0;
      az_len  <= CW'(AZ_BOOT);
      long_zi <= 1'b0;
      pos_q   <= 1'b0;
      valid_o <= 1'b0;
      neg_o   <= 1'b0;
      ovr_o   <= 1'b0;
      thou_o  <= 1'b0;
      bcd_o   <= '0;
    end else begin
      valid_o <= dei_done;
      if (adv) begin
        ph <= phase_e'(ph + 2'd1);
        pc <= '0;
      end else if (tick) begin
        pc <= pc + CW'(1);
      end
      if (int_end) pos_q <= cmp_i;
      if (dei_done) begin
        long_zi <= dei_full;
        az_len  <= az_next;
        neg_o   <= ~pos_q;
        ovr_o   <= dei_full;
        thou_o  <= dei_full ? 1'b0 : cnt_half;
        bcd_o   <= dei_full ? '0 : cnt_bcd;
      end
    end
  end

  assign phase_o   = phase_onehot(ph);
  assign ref_pos_o = pos_q;

endmodule

// File: rtl/dslope_chk.sv
module dslope_chk #(
  parameter int DIV     = 4,
  parameter int INT_CNT = 1000,
  parameter int DEI_MAX = 2000,
  parameter int ZI_NORM = 140,
  parameter int ZI_LONG = 740,
  parameter int CYCLE   = 4000,
  parameter int DIGITS  = 3
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                cmp_i,
  input logic                tick_i,
  input logic [3:0]          phase_o,
  input logic                ref_pos_o,
  input logic                valid_o,
  input logic                neg_o,
  input logic                ovr_o,
  input logic                thou_o,
  input logic [4*DIGITS-1:0] bcd_o
);

  localparam int AZ_BOOT = CYCLE - INT_CNT - DEI_MAX - ZI_LONG;

  logic [3:0] prev_ph;
  int         run;
  int         since_int;
  logic       seen_int;
  logic       chg;
  logic       rise_int;

  assign chg      = (phase_o != prev_ph);
  assign rise_int = phase_o[1] & ~prev_ph[1];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_ph   <= 4'b0001;
      run       <= 0;
      since_int <= 0;
      seen_int  <= 1'b0;
    end else begin
      prev_ph   <= phase_o;
      run       <= chg ? 1 : run + 1;
      since_int <= rise_int ? 1 : since_int + 1;
      if (rise_int) seen_int <= 1'b1;
    end
  end

  p_tick_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    chg |-> $past(tick_i));

  p_boot_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    chg && prev_ph[0] && !seen_int |-> run == AZ_BOOT * DIV);

  p_onehot_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(phase_o) == 1);

  p_order_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    chg |-> phase_o == {prev_ph[2:0], prev_ph[3]});

  p_int_len_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    chg && prev_ph[1] |-> run == INT_CNT * DIV);

  p_pol_cap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    chg && prev_ph[1] |-> ref_pos_o == $past(cmp_i));

  p_pol_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !(chg && prev_ph[1]) |-> $stable(ref_pos_o));

  p_cross_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o && !ovr_o |-> $past(cmp_i) != ref_pos_o);

  p_dei_len_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    chg && prev_ph[2] |-> run <= DEI_MAX * DIV);

  p_ovr_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    ovr_o |-> bcd_o == '0 && !thou_o);

  p_zi_len_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    chg && prev_ph[3] |-> run == (ovr_o ? ZI_LONG : ZI_NORM) * DIV);

  p_cycle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_int && seen_int |-> since_int == CYCLE * DIV);

  p_strobe_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);

  p_strobe_at_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> phase_o[3] && prev_ph[2]);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |-> $stable(bcd_o) && $stable(ovr_o) && $stable(neg_o) && $stable(thou_o));

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit_chk
    p_digit_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      bcd_o[4*i+:4] <= 4'd9);
  end

endmodule

bind dslope_seq dslope_chk #(
  .DIV     (DIV),
  .INT_CNT (INT_CNT),
  .DEI_MAX (DEI_MAX),
  .ZI_NORM (ZI_NORM),
  .ZI_LONG (ZI_LONG),
  .CYCLE   (CYCLE),
  .DIGITS  (DIGITS)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .cmp_i     (cmp_i),
  .tick_i    (tick),
  .phase_o   (phase_o),
  .ref_pos_o (ref_pos_o),
  .valid_o   (valid_o),
  .neg_o     (neg_o),
  .ovr_o     (ovr_o),
  .thou_o    (thou_o),
  .bcd_o     (bcd_o)
);

// File: tb/sim_dslope_seq.sv
module sim_dslope_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp;
  logic [3:0]  phase_o;
  logic        ref_pos_o, valid_o, neg_o, ovr_o, thou_o;
  logic [11:0] bcd_o;

  int integ = 0;
  assign cmp = (integ > 0);

  dslope_seq u0 (
    .clk_i     (clk),
    .rst_i     (rst),
    .cmp_i     (cmp),
    .phase_o   (phase_o),
    .ref_pos_o (ref_pos_o),
    .valid_o   (valid_o),
    .neg_o     (neg_o),
    .ovr_o     (ovr_o),
    .thou_o    (thou_o),
    .bcd_o     (bcd_o)
  );

  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model state (counts, integers)
  int   e     = 0;
  bit   live  = 0;
  int   mph   = 0;
  int   mn    = 0;
  int   maz   = 260;
  bit   mlong = 0;
  bit   mpos  = 0;
  int   vin   = 0;
  int   done  = 0;
  int   erd   = 0;
  bit   eneg  = 0;
  bit   eovr  = 0;
  bit   evld  = 0;
  int   vq[$] = '{500, -250, 0, 2500, 1999, -3000, 7, 1234};

  task automatic close_dei(bit ovr);
    eovr  = ovr;
    erd   = ovr ? 0 : mn;
    eneg  = !mpos;
    evld  = 1;
    mlong = ovr;
    maz   = 4000 - 1000 - (ovr ? 2000 : mn + 1) - (ovr ? 740 : 140);
    mph   = 3;
    mn    = 0;
    done++;
  endtask

  task automatic count_step();
    bit c;
    c = (integ > 0);
    case (mph)
      0: begin
        mn++;
        if (mn == maz) begin
          mph   = 1;
          mn    = 0;
          integ = 0;
          vin   = (vq.size() > 0) ? vq.pop_front() : 100;
        end
      end
      1: begin
        mn++;
        integ += vin;
        if (mn == 1000) begin
          mpos = c;
          mph  = 2;
          mn   = 0;
        end
      end
      2: begin
        if (c != mpos)      close_dei(1'b0);
        else if (mn == 1999) close_dei(1'b1);
        else begin
          mn++;
          integ += mpos ? -1000 : 1000;
        end
      end
      default: begin
        mn++;
        if (mn == (mlong ? 740 : 140)) begin
          mph   = 0;
          mn    = 0;
          integ = 0;
        end
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst) begin
      #1;
      e++;
      live = 1;
      evld = 0;
      if (e % 4 == 0) count_step();
    end
  end

  // Per-clock comparison and phase-length bookkeeping
  int lastp     = 1;
  int run       = 1;
  int int_start = 0;

  always @(negedge clk) begin
    if (live && !rst) begin
      int dec;
      dec = int'(thou_o) * 1000 + int'(bcd_o[11:8]) * 100 +
            int'(bcd_o[7:4]) * 10 + int'(bcd_o[3:0]);
      check("R3",  "phase",     int'(phase_o),   1 << mph);
      check("R5",  "ref_pos",   int'(ref_pos_o), int'(mpos));
      check("R10", "valid",     int'(valid_o),   int'(evld));
      check("R6",  "reading",   dec,             erd);
      check("R7",  "overrange", int'(ovr_o),     int'(eovr));
      check("R10", "negative",  int'(neg_o),     int'(eneg));
      if (valid_o) begin
        check("R11", "units",     int'(bcd_o[3:0]),  erd % 10);
        check("R11", "tens",      int'(bcd_o[7:4]),  (erd / 10) % 10);
        check("R11", "hundreds",  int'(bcd_o[11:8]), (erd / 100) % 10);
        check("R11", "thousands", int'(thou_o),      erd / 1000);
      end
      if (int'(phase_o) != lastp) begin
        check("R1", "phase change edge mod 4", e % 4, 0);
        case (lastp)
          1: if (int_start == 0) check("R2", "boot auto-zero clocks", run, 1040);
          2: check("R4", "integrate clocks", run, 4000);
          4: check("R6", "de-integrate clocks", run, eovr ? 8000 : (erd + 1) * 4);
          8: check("R8", "zeroing clocks", run, eovr ? 2960 : 560);
          default: ;
        endcase
        if (phase_o == 4'b0010) begin
          if (int_start > 0) check("R9", "cycle clocks", e - int_start, 16000);
          int_start = e;
        end
        lastp = int'(phase_o);
        run   = 1;
      end else begin
        run++;
      end
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2", "reset phase",   int'(phase_o),   1);
    check("R2", "reset valid",   int'(valid_o),   0);
    check("R2", "reset bcd",     int'(bcd_o),     0);
    check("R2", "reset thou",    int'(thou_o),    0);
    check("R2", "reset ovr",     int'(ovr_o),     0);
    check("R2", "reset neg",     int'(neg_o),     0);
    check("R2", "reset ref_pos", int'(ref_pos_o), 0);
    rst = 1'b0;
    for (int cyc = 0; cyc < 180000 && done < 8; cyc++) @(negedge clk);
    if (done < 8) check("R9", "watchdog conversions", done, 8);
    repeat (200) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule